// File: doc/BRIEF.md
# Nine-Bit Multidrop UART Transmitter

This block is the transmit half of a UART that can run either as a plain 8-bit serial port or in a 9-bit multidrop mode. In multidrop mode the ninth bit tells receivers on a shared line whether a character is a station address or payload. A host drives a small register write port to fill a transmit queue and to set a mode register and a 16-bit bit-period divisor. A serializer drains the queue one frame at a time onto a single line that idles high.

The address/data flag is not read from the mode register while a frame goes out. Each queue entry holds the byte and a one-bit tag. The tag is copied from the mode register at the cycle the byte is written. Software can therefore queue an address byte, flip the flag, and queue a run of payload bytes without waiting for the line to drain. Later rewrites of the mode register never change bytes that are already queued.

Register write decode on `wr_addr`: 0 pushes `wr_data` into the queue, 1 writes the mode register, 2 writes the divisor's low byte, and 3 writes its high byte. In the mode register, bit 2 is the address/data flag and bit 3 selects multidrop mode. The other bits are not stored.

Top module: `mdrop_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `overrun` is 0.
- R2: With mode bit 3 at 0, each frame is a 0 start bit, the eight data bits least-significant first, then a 1 stop bit. That is 10 bit periods, with no extra bit.
- R3: With mode bit 3 at 1, each frame is a 0 start bit, eight data bits least-significant first, the entry's tag, then a 1 stop bit. That is 11 bit periods.
- R4: A byte's tag is the value of mode bit 2 at the clock edge where the byte is written (1 = address, 0 = data). Rewriting mode bit 2 afterwards does not change the ninth bit of any queued or in-flight byte.
- R5: Mode bit 3 is sampled when a frame begins. A mode write during a frame does not change that frame's length or content.
- R6: Every bit lasts the number of clock cycles in the divisor register (written through addresses 2 and 3). A divisor of 0 acts as 1.
- R7: The queue holds 16 entries and sends them in write order. `fifo_full` and `fifo_empty` report its state and are never both 1.
- R8: A queue write while `fifo_full` is 1 is dropped and is never sent. It sets `overrun`, which stays 1 until reset.
- R9: A frame starts only when the queue is non-empty and no frame is in progress. The start bit appears the cycle after the entry leaves the queue. The line is high whenever no frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: 0 queue, 1 mode, 2 divisor low, 3 divisor high |
| wr_data | input | 8 | Write data |
| txd | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | A frame is being sent |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_empty | output | 1 | Queue holds no entry |
| overrun | output | 1 | Sticky: a queue write was dropped |

## Verification
The assertions assume that `wr_addr` and `wr_data` are held only while `wr_en` is high, that the host never changes the divisor while a frame is on the line, and that every write lasts a single cycle. The stimulus keeps within these limits. Writes are driven one cycle at a time on the falling clock edge, and the divisor is reprogrammed only once the queue has drained and the line is idle. The mode register, by contrast, is rewritten freely, both between queue writes and in the middle of frames. Queue writes while full are issued only in the dedicated overrun sequence.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;

    localparam int DATA_W       = 8;
    localparam int FIFO_DEPTH   = 16;
    localparam int DIV_W        = 16;
    localparam int MODE_TAG_BIT = 2;
    localparam int MODE_MD_BIT  = 3;
    localparam int FRAME_W      = DATA_W + 3;

    typedef enum logic [1:0] {
        ADDR_TXDATA = 2'd0,
        ADDR_MODE   = 2'd1,
        ADDR_DIV_LO = 2'd2,
        ADDR_DIV_HI = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic              tag;
        logic [DATA_W-1:0] data;
    } tx_entry_t;

    localparam int ENTRY_W = $bits(tx_entry_t);

    typedef logic [FRAME_W-1:0] frame_t;

    // Frame image shifted out LSB first; unused top bits are idle ones.
    function automatic frame_t build_frame(input tx_entry_t e, input logic md);
        frame_t f;
        if (md)
            f = {1'b1, e.tag, e.data, 1'b0};
        else
            f = {2'b11, e.data, 1'b0};
        return f;
    endfunction

    function automatic int unsigned frame_bits(input logic md);
        return md ? FRAME_W : FRAME_W - 1;
    endfunction

endpackage

// File: rtl/mdrop_regs.sv
module mdrop_regs
    import mdrop_pkg::*;
#(
    parameter int DW        = DATA_W,
    parameter int DIVW      = DIV_W,
    parameter int DIV_RESET = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic            mode_tag,
    output logic            mode_md,
    output logic [DIVW-1:0] divisor,
    output logic            push,
    output tx_entry_t       push_entry
);

    localparam int HI_W = DIVW - DW;

    reg_addr_e sel;
    assign sel = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_tag <= 1'b0;
            mode_md  <= 1'b0;
            divisor  <= DIVW'(DIV_RESET);
        end else if (wr_en) begin
            case (sel)
                ADDR_MODE: begin
                    mode_tag <= wr_data[MODE_TAG_BIT];
                    mode_md  <= wr_data[MODE_MD_BIT];
                end
                ADDR_DIV_LO: divisor[DW-1:0]    <= wr_data;
                ADDR_DIV_HI: divisor[DIVW-1:DW] <= wr_data[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // The tag is taken from the register as it stands at the write edge.
    assign push             = wr_en && (sel == ADDR_TXDATA);
    assign push_entry.tag   = mode_tag;
    assign push_entry.data  = wr_data;

endmodule

// File: rtl/mdrop_fifo.sv
module mdrop_fifo
    import mdrop_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      push,
    input  tx_entry_t push_entry,
    input  logic      pop,
    output tx_entry_t head,
    output logic      full,
    output logic      empty,
    output logic      overrun
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_entry_t         mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     count;
    logic              do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= push_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            overrun <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= next_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (push && full)
                overrun <= 1'b1;
        end
    end

endmodule

// File: rtl/mdrop_baud.sv
module mdrop_baud
    import mdrop_pkg::*;
#(
    parameter int DIVW = DIV_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [DIVW-1:0] divisor,
    output logic            tick
);

    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] last;

    assign last = (divisor == '0) ? '0 : divisor - 1'b1;
    assign tick = run && (cnt >= last);

    // Restarts from zero with every frame so the first bit is a full period.
    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt >= last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/mdrop_serializer.sv
module mdrop_serializer
    import mdrop_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      empty,
    input  tx_entry_t head,
    input  logic      mode_md,
    input  logic      tick,
    output logic      pop,
    output logic      busy,
    output logic      txd
);

    localparam int CW = $clog2(FW + 1);

    logic [FW-1:0] shreg;
    logic [CW-1:0] left;

    assign pop = !busy && !empty;
    assign txd = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            left  <= '0;
            busy  <= 1'b0;
        end else if (pop) begin
            shreg <= build_frame(head, mode_md);
            left  <= CW'(frame_bits(mode_md));
            busy  <= 1'b1;
        end else if (busy && tick) begin
            shreg <= {1'b1, shreg[FW-1:1]};
            left  <= left - 1'b1;
            if (left == CW'(1))
                busy <= 1'b0;
        end
    end

endmodule

// File: rtl/mdrop_uart_tx.sv
module mdrop_uart_tx
    import mdrop_pkg::*;
#(
    parameter int DEPTH     = FIFO_DEPTH,
    parameter int DIVW      = DIV_W,
    parameter int DIV_RESET = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tx_busy,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              overrun
);

    logic            mode_tag, mode_md;
    logic [DIVW-1:0] divisor;
    logic            fifo_push, fifo_pop, bit_tick;
    tx_entry_t       push_entry, head;

    mdrop_regs #(.DW(DATA_W), .DIVW(DIVW), .DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mode_tag(mode_tag), .mode_md(mode_md), .divisor(divisor),
        .push(fifo_push), .push_entry(push_entry)
    );

    mdrop_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(fifo_push), .push_entry(push_entry),
        .pop(fifo_pop), .head(head), .full(fifo_full), .empty(fifo_empty),
        .overrun(overrun)
    );

    mdrop_baud #(.DIVW(DIVW)) u_baud (
        .clk(clk), .rst(rst), .run(tx_busy), .divisor(divisor), .tick(bit_tick)
    );

    mdrop_serializer #(.FW(FRAME_W)) u_ser (
        .clk(clk), .rst(rst), .empty(fifo_empty), .head(head), .mode_md(mode_md),
        .tick(bit_tick), .pop(fifo_pop), .busy(tx_busy), .txd(txd)
    );

endmodule

// File: rtl/mdrop_checker.sv
module mdrop_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       txd,
    input logic       busy,
    input logic       full,
    input logic       empty,
    input logic       overrun,
    input logic       pop,
    input logic       tick
);

    a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && full && !pop) |=> (overrun && full));

    a_r9_start_follows_pop: assert property (@(posedge clk) disable iff (rst)
        pop |=> (busy && !txd));

    a_r9_no_pop_mid_frame: assert property (@(posedge clk) disable iff (rst)
        busy |-> !pop);

    a_r6_tick_inside_frame: assert property (@(posedge clk) disable iff (rst)
        tick |-> busy);

endmodule

bind mdrop_uart_tx mdrop_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .txd(txd),
    .busy(tx_busy), .full(fifo_full), .empty(fifo_empty), .overrun(overrun),
    .pop(fifo_pop), .tick(bit_tick)
);

// File: tb/mdrop_uart_tx_test.sv
module mdrop_uart_tx_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, tx_busy, fifo_full, fifo_empty, overrun;

    int checks = 0;
    int fails  = 0;
    int ediv   = 4;
    logic mode_tag = 1'b0;
    logic mode_md  = 1'b0;
    logic [9:0] exp_q [$];   // {md, tag, data}

    always #4 clk = ~clk;

    mdrop_uart_tx uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .txd(txd), .tx_busy(tx_busy), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .overrun(overrun)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic md, input logic tag);
        logic [7:0] v;
        v = 8'h00;
        v[3] = md;
        v[2] = tag;
        wr(2'd1, v);
        mode_md  = md;
        mode_tag = tag;
    endtask

    task automatic set_div(input int d);
        wr(2'd3, d[15:8]);
        wr(2'd2, d[7:0]);
        ediv = (d == 0) ? 1 : d;
    endtask

    // Queue write: predicted dropped when the full flag is set going in.
    task automatic push_byte(input logic [7:0] d);
        logic was_full;
        @(negedge clk);
        was_full = fifo_full;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = d;
        if (!was_full) exp_q.push_back({mode_md, mode_tag, d});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2 * ediv + 4) @(negedge clk);
    endtask

    // Frame monitor: samples each bit at its middle.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && txd == 1'b0) begin
                logic [9:0] e;
                logic [10:0] bits;
                int len;
                int d;
                d = ediv;
                if (exp_q.size() == 0) begin
                    e = 10'h3ff;
                    checks++; fails++;
                    $display("FAIL R7 actual=unexpected frame expected=none");
                end else begin
                    e = exp_q[0];
                end
                len = e[9] ? 11 : 10;
                bits = '1;
                repeat ((d - 1) / 2) @(negedge clk);
                bits[0] = txd;
                for (int i = 1; i < len; i++) begin
                    repeat (d) @(negedge clk);
                    bits[i] = txd;
                end
                chk("R9 start bit", bits[0], 1'b0);
                chk(e[9] ? "R3 data bits" : "R2 data bits", bits[8:1], e[7:0]);
                if (e[9]) begin
                    chk("R4 ninth bit tag", bits[9], e[8]);
                    chk("R3 stop bit", bits[10], 1'b1);
                end else begin
                    chk("R2 stop bit", bits[9], 1'b1);
                end
                if (exp_q.size() != 0) void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd", txd, 1'b1);
        chk("R1 busy", tx_busy, 1'b0);
        chk("R1 empty", fifo_empty, 1'b1);
        chk("R1 full", fifo_full, 1'b0);
        chk("R1 overrun", overrun, 1'b0);

        // R2: plain 8-bit frames, tag toggled but never sent
        set_div(4);
        set_mode(1'b0, 1'b0);
        for (int i = 0; i < 6; i++) begin
            push_byte(8'($urandom));
            set_mode(1'b0, ~mode_tag);
        end
        drain();

        // R4: address then data with the flag toggled during transmission
        set_div(6);
        set_mode(1'b1, 1'b1);
        push_byte(8'h5A);
        set_mode(1'b1, 1'b0);
        push_byte(8'h11);
        push_byte(8'h22);
        set_mode(1'b1, 1'b1);
        set_mode(1'b1, 1'b0);
        push_byte(8'h33);
        set_mode(1'b1, 1'b1);
        drain();

        // R3/R4 random mix of queue writes and flag flips
        set_div(2 + int'($urandom % 8));
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 40; i++) begin
            if (($urandom % 10) < 6 && !fifo_full)
                push_byte(8'($urandom));
            else
                set_mode(1'b1, 1'($urandom));
            repeat ($urandom % 6) @(negedge clk);
        end
        drain();

        // R6: divisor zero behaves as one
        set_div(0);
        set_mode(1'b0, 1'b0);
        push_byte(8'hA5);
        drain();

        // R6: start bit length equals the divisor
        set_div(5);
        push_byte(8'h01);
        begin
            int lo;
            lo = 0;
            while (txd == 1'b1) @(negedge clk);
            while (txd == 1'b0) begin lo++; @(negedge clk); end
            chk("R6 start bit cycles", lo, 5);
        end
        drain();

        // R5: mode rewritten mid-frame does not alter the frame
        set_div(20);
        set_mode(1'b1, 1'b1);
        push_byte(8'hC3);
        while (txd == 1'b1) @(negedge clk);
        repeat (30) @(negedge clk);
        set_mode(1'b0, 1'b0);
        chk("R5 busy mid frame", tx_busy, 1'b1);
        drain();
        push_byte(8'h3C);
        drain();

        // R7/R8: fill past capacity
        set_div(100);
        set_mode(1'b1, 1'b0);
        for (int i = 0; i < 20; i++) push_byte(8'(8'h80 + i));
        @(negedge clk);
        chk("R7 full flag", fifo_full, 1'b1);
        chk("R8 overrun set", overrun, 1'b1);
        chk("R7 queued count", exp_q.size(), 17);
        drain();
        chk("R8 overrun sticky", overrun, 1'b1);
        chk("R7 empty after drain", fifo_empty, 1'b1);
        chk("R9 idle line", txd, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule